// File: doc/BRIEF.md
# PCI Configuration I/O Window Decoder

This block sits inside one function's PCI configuration space. It holds the base-address registers for two I/O windows: a 128-byte power-management window and a 16-byte SMBus window. Each window also has an enable byte that lives in its own configuration location, not in the command register. Software programs the bases and the enables through a dword-addressed configuration write port with byte enables. A combinational read port returns the stored values.

Each incoming I/O address is compared against both windows at once. For each window the block gives a hit flag and the offset of the address within that window. The base registers rewrite themselves on every write that touches them. Bits below the window size clear, bits above bit 15 clear, and bit 0 (the I/O-space indicator) always reads as one. After reset both bases hold that indicator value alone and both windows are off.

Top module: `cfg_io_window_dec`

## Requirements
- R1: After reset, dwords 0x12 and 0x24 read 0x00000001, dwords 0x10 and 0x34 read 0x00000000, and neither hit output is high.
- R2: Any write to dword 0x12 (config byte 0x48) that enables at least one byte stores the merged value ANDed with 0x0000FF80 and ORed with 1.
- R3: Any write to dword 0x24 (config byte 0x90) that enables at least one byte stores the merged value ANDed with 0x0000FFF0 and ORed with 1.
- R4: Only the byte lanes whose enable bit is set replace stored bytes, and the masking of R2/R3 is applied after that merge. A write that enables only lanes 2 and 3 leaves a base unchanged.
- R5: The power-management enable byte is config byte 0x41, which is dword 0x10, lane 1 (read bits 15:8). All 8 bits are stored, and bit 7 turns the window on.
- R6: The SMBus enable byte is config byte 0xD2, which is dword 0x34, lane 2 (read bits 23:16). A write keeps only its low 4 bits, and bit 0 turns the window on.
- R7: pm_hit is high exactly when the power-management enable is on and io_addr[15:7] equals base[15:7]. pm_off equals io_addr[6:0].
- R8: The SMBus window matches when its enable is on and io_addr[15:4] equals base[15:4]. smb_off equals io_addr[3:0].
- R9: When both windows match the same address, pm_hit is high and smb_hit is low.
- R10: A read in the same cycle as a write to the same dword returns the value from before the write. The new value appears after the clock edge.
- R11: Dwords other than 0x10, 0x12, 0x24 and 0x34 read zero, and writes to them change no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Dword index into configuration space, shared by read and write |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, from the stored state before any write in the same cycle |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Address falls in the enabled power-management window |
| pm_off | output | 7 | Offset within the power-management window |
| smb_hit | output | 1 | Address falls in the enabled SMBus window and not in the power-management one |
| smb_off | output | 4 | Offset within the SMBus window |

## Verification
The assertions assume that cfg_addr and io_addr settle between clock edges, and that an unknown value on cfg_be never comes with cfg_wr high. The bench drives every input on the falling edge and samples one time unit later, so the combinational read and decode paths are steady when observed. One test deliberately places the SMBus base inside the power-management window so that the priority rule is exercised. Another holds a write and a read on the same dword in one cycle to show that the read returns the value from before the write.

// File: rtl/cfgwin_pkg.sv
// Shared constants for the configuration I/O window decoder.
// Assumes a 256-byte configuration space addressed as 64 dwords.
package cfgwin_pkg;
    localparam int PM_BASE_DW  = 'h12;   // dword holding config byte 0x48
    localparam int SMB_BASE_DW = 'h24;   // dword holding config byte 0x90
    localparam int PM_EN_DW    = 'h10;   // dword holding config byte 0x41
    localparam int SMB_EN_DW   = 'h34;   // dword holding config byte 0xD2
    localparam int PM_EN_LANE  = 1;
    localparam int SMB_EN_LANE = 2;
    localparam int PM_EN_BIT   = 7;
    localparam int SMB_EN_BIT  = 0;
    localparam logic [7:0] PM_EN_KEEP  = 8'hFF;
    localparam logic [7:0] SMB_EN_KEEP = 8'h0F;
endpackage

// File: rtl/cfgwin_base_reg.sv
// Self-masking I/O base register.
// Holds only bits [IO_W-1:SZ_LOG2]. The low bits read as zero except bit 0,
// which always reads one, and the bits above IO_W read as zero.
// Assumes IO_W is a multiple of 8 and no larger than 32.
module cfgwin_base_reg #(
    parameter int IO_W    = 16,
    parameter int SZ_LOG2 = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_sel,
    input  logic [IO_W/8-1:0]       be,
    input  logic [IO_W-1:0]         wdata,
    output logic [IO_W-1:SZ_LOG2]   base_hi,
    output logic [31:0]             rdata
);
    localparam int LANES = IO_W / 8;

    logic [IO_W-1:SZ_LOG2] hi_q;
    logic [IO_W-1:SZ_LOG2] merged_hi;
    logic                  unused_lo;

    assign unused_lo = ^wdata[SZ_LOG2-1:0];

    // Merge the enabled lanes into the kept bits; the masked bits drop out.
    always_comb begin
        merged_hi = hi_q;
        for (int i = SZ_LOG2; i < IO_W; i++) begin
            if (be[i/8]) merged_hi[i] = wdata[i];
        end
    end

    // Store the masked value on any write that overlaps this dword.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hi_q <= '0;
        else if (wr_sel && (|be))   hi_q <= merged_hi;
    end

    // Present the stored value with the I/O indicator forced.
    always_comb begin
        rdata = '0;
        rdata[IO_W-1:SZ_LOG2] = hi_q;
        rdata[0] = 1'b1;
    end

    assign base_hi = hi_q;

    localparam int CHK_LANES = LANES;
    if (CHK_LANES > 4) begin : g_bad_width
        initial $error("IO_W wider than a dword");
    end
endmodule

// File: rtl/cfgwin_en_byte.sv
// One configuration byte that holds a window enable.
// Bits outside KEEP always read zero. The byte resets to zero.
module cfgwin_en_byte #(
    parameter logic [7:0] KEEP = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_sel,
    input  logic       lane_be,
    input  logic [7:0] wdata8,
    output logic [7:0] q
);
    // Capture the masked byte when its lane is written.
    always_ff @(posedge clk) begin
        if (!rst_n)                 q <= 8'h00;
        else if (wr_sel && lane_be) q <= wdata8 & KEEP;
    end
endmodule

// File: rtl/cfgwin_decode.sv
// Aligned window compare for a window of 2**SZ_LOG2 bytes.
// Assumes the base is aligned to the window size. Purely combinational.
module cfgwin_decode #(
    parameter int IO_W    = 16,
    parameter int SZ_LOG2 = 7
) (
    input  logic [IO_W-1:0]       io_addr,
    input  logic [IO_W-1:SZ_LOG2] base_hi,
    input  logic                  en,
    output logic                  hit,
    output logic [SZ_LOG2-1:0]    off
);
    // Compare the upper address bits and split off the in-window offset.
    always_comb begin
        hit = en && (io_addr[IO_W-1:SZ_LOG2] == base_hi);
        off = io_addr[SZ_LOG2-1:0];
    end
endmodule

// File: rtl/cfg_io_window_dec.sv
// Top level: two I/O window base registers, their enable bytes, a config
// read mux and the window decoders. Reads are combinational from the stored
// state, so a read in a write cycle returns the value from before the write.
// The power-management window takes priority over the SMBus window.
module cfg_io_window_dec
    import cfgwin_pkg::*;
#(
    parameter int CFG_AW      = 6,
    parameter int IO_W        = 16,
    parameter int PM_SZ_LOG2  = 7,
    parameter int SMB_SZ_LOG2 = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [3:0]             cfg_be,
    input  logic [31:0]            cfg_wdata,
    output logic [31:0]            cfg_rdata,
    input  logic [IO_W-1:0]        io_addr,
    output logic                   pm_hit,
    output logic [PM_SZ_LOG2-1:0]  pm_off,
    output logic                   smb_hit,
    output logic [SMB_SZ_LOG2-1:0] smb_off
);
    localparam logic [CFG_AW-1:0] A_PM_BASE  = CFG_AW'(PM_BASE_DW);
    localparam logic [CFG_AW-1:0] A_SMB_BASE = CFG_AW'(SMB_BASE_DW);
    localparam logic [CFG_AW-1:0] A_PM_EN    = CFG_AW'(PM_EN_DW);
    localparam logic [CFG_AW-1:0] A_SMB_EN   = CFG_AW'(SMB_EN_DW);
    localparam int LANES = IO_W / 8;

    logic [IO_W-1:PM_SZ_LOG2]  pm_base_hi;
    logic [IO_W-1:SMB_SZ_LOG2] smb_base_hi;
    logic [31:0]               pm_base_rd, smb_base_rd;
    logic [7:0]                pm_en_q, smb_en_q;
    logic                      pm_match, smb_match;
    logic                      unused_wd;

    assign unused_wd = ^cfg_wdata[31:24];

    cfgwin_base_reg #(.IO_W(IO_W), .SZ_LOG2(PM_SZ_LOG2)) u_pm_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (cfg_wr && (cfg_addr == A_PM_BASE)),
        .be      (cfg_be[LANES-1:0]),
        .wdata   (cfg_wdata[IO_W-1:0]),
        .base_hi (pm_base_hi),
        .rdata   (pm_base_rd)
    );

    cfgwin_base_reg #(.IO_W(IO_W), .SZ_LOG2(SMB_SZ_LOG2)) u_smb_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (cfg_wr && (cfg_addr == A_SMB_BASE)),
        .be      (cfg_be[LANES-1:0]),
        .wdata   (cfg_wdata[IO_W-1:0]),
        .base_hi (smb_base_hi),
        .rdata   (smb_base_rd)
    );

    cfgwin_en_byte #(.KEEP(PM_EN_KEEP)) u_pm_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (cfg_wr && (cfg_addr == A_PM_EN)),
        .lane_be (cfg_be[PM_EN_LANE]),
        .wdata8  (cfg_wdata[PM_EN_LANE*8 +: 8]),
        .q       (pm_en_q)
    );

    cfgwin_en_byte #(.KEEP(SMB_EN_KEEP)) u_smb_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (cfg_wr && (cfg_addr == A_SMB_EN)),
        .lane_be (cfg_be[SMB_EN_LANE]),
        .wdata8  (cfg_wdata[SMB_EN_LANE*8 +: 8]),
        .q       (smb_en_q)
    );

    cfgwin_decode #(.IO_W(IO_W), .SZ_LOG2(PM_SZ_LOG2)) u_pm_dec (
        .io_addr (io_addr),
        .base_hi (pm_base_hi),
        .en      (pm_en_q[PM_EN_BIT]),
        .hit     (pm_match),
        .off     (pm_off)
    );

    cfgwin_decode #(.IO_W(IO_W), .SZ_LOG2(SMB_SZ_LOG2)) u_smb_dec (
        .io_addr (io_addr),
        .base_hi (smb_base_hi),
        .en      (smb_en_q[SMB_EN_BIT]),
        .hit     (smb_match),
        .off     (smb_off)
    );

    // Resolve overlapping windows in favour of power management.
    always_comb begin
        pm_hit  = pm_match;
        smb_hit = smb_match && !pm_match;
    end

    // Select the read data for the addressed dword; unmapped dwords read zero.
    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            A_PM_BASE:  cfg_rdata = pm_base_rd;
            A_SMB_BASE: cfg_rdata = smb_base_rd;
            A_PM_EN:    cfg_rdata[PM_EN_LANE*8 +: 8]  = pm_en_q;
            A_SMB_EN:   cfg_rdata[SMB_EN_LANE*8 +: 8] = smb_en_q;
            default:    cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfgwin_dec_chk.sv
// Checker for cfg_io_window_dec, attached through bind. Port level only.
module cfgwin_dec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [5:0]  cfg_addr,
    input logic [31:0] cfg_rdata,
    input logic        pm_hit,
    input logic        smb_hit
);
    AST_HITS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pm_hit && smb_hit)); // R9

    AST_NO_HIT_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!pm_hit && !smb_hit)); // R1

    AST_PM_BASE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 6'h12) |-> (cfg_rdata[0] && cfg_rdata[6:1] == 6'd0 && cfg_rdata[31:16] == 16'd0)); // R2

    AST_SMB_BASE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 6'h24) |-> (cfg_rdata[0] && cfg_rdata[3:1] == 3'd0 && cfg_rdata[31:16] == 16'd0)); // R3

    AST_SMB_EN_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 6'h34) |-> (cfg_rdata[23:20] == 4'd0)); // R6

    AST_READ_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_wr) && $stable(cfg_addr)) |-> $stable(cfg_rdata)); // R10
endmodule

bind cfg_io_window_dec cfgwin_dec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .pm_hit    (pm_hit),
    .smb_hit   (smb_hit)
);

// File: tb/cfg_io_window_dec_tb.sv
module cfg_io_window_dec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        pm_hit, smb_hit;
    logic [6:0]  pm_off;
    logic [3:0]  smb_off;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    cfg_io_window_dec u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .pm_hit(pm_hit), .pm_off(pm_off),
        .smb_hit(smb_hit), .smb_off(smb_off)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(posedge clk);
        #1 cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic probe(input logic [15:0] a);
        io_addr = a;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        cfg_read(6'h12, d); check("R1 pm base", d, 32'h1);
        cfg_read(6'h24, d); check("R1 smb base", d, 32'h1);
        cfg_read(6'h10, d); check("R1 pm en", d, 32'h0);
        cfg_read(6'h34, d); check("R1 smb en", d, 32'h0);
        probe(16'h0000);
        check("R1 hits", {30'd0, pm_hit, smb_hit}, 32'h0);
    endtask

    task automatic t_pm_base();
        logic [31:0] d;
        cfg_write(6'h12, 4'hF, 32'hABCD_1234);
        cfg_read(6'h12, d); check("R2 pm base mask", d, 32'h0000_1201);
    endtask

    task automatic t_smb_base();
        logic [31:0] d;
        cfg_write(6'h24, 4'hF, 32'hFFFF_5678);
        cfg_read(6'h24, d); check("R3 smb base mask", d, 32'h0000_5671);
    endtask

    task automatic t_partial();
        logic [31:0] d;
        cfg_write(6'h12, 4'b0010, 32'h0000_3400);
        cfg_read(6'h12, d); check("R4 lane1 merge", d, 32'h0000_3401);
        cfg_write(6'h12, 4'b0001, 32'h0000_00FF);
        cfg_read(6'h12, d); check("R4 lane0 merge", d, 32'h0000_3481);
        cfg_write(6'h12, 4'b1100, 32'hFFFF_0000);
        cfg_read(6'h12, d); check("R4 upper lanes", d, 32'h0000_3481);
    endtask

    task automatic t_pm_enable();
        logic [31:0] d;
        cfg_write(6'h10, 4'b0010, 32'h0000_8500);
        cfg_read(6'h10, d); check("R5 pm en byte", d, 32'h0000_8500);
        probe(16'h34C5);
        check("R7 pm hit", {31'd0, pm_hit}, 32'h1);
        check("R7 pm off", {25'd0, pm_off}, 32'h45);
        probe(16'h347F); check("R7 below window", {31'd0, pm_hit}, 32'h0);
        probe(16'h3500); check("R7 above window", {31'd0, pm_hit}, 32'h0);
        cfg_write(6'h10, 4'b0010, 32'h0000_7F00);
        cfg_read(6'h10, d); check("R5 pm en bits kept", d, 32'h0000_7F00);
        probe(16'h34C5); check("R5 pm disabled", {31'd0, pm_hit}, 32'h0);
    endtask

    task automatic t_smb_enable();
        logic [31:0] d;
        cfg_write(6'h34, 4'b0100, 32'h00FF_0000);
        cfg_read(6'h34, d); check("R6 smb en nibble", d, 32'h000F_0000);
        probe(16'h567A);
        check("R8 smb hit", {31'd0, smb_hit}, 32'h1);
        check("R8 smb off", {28'd0, smb_off}, 32'hA);
        probe(16'h5680); check("R8 outside", {31'd0, smb_hit}, 32'h0);
        cfg_write(6'h34, 4'b0100, 32'h000E_0000);
        cfg_read(6'h34, d); check("R6 smb en cleared", d, 32'h000E_0000);
        probe(16'h567A); check("R6 smb disabled", {31'd0, smb_hit}, 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        cfg_write(6'h10, 4'b0010, 32'h0000_8000);
        cfg_write(6'h34, 4'b0100, 32'h0001_0000);
        cfg_write(6'h24, 4'hF, 32'h0000_3490);
        cfg_read(6'h24, d); check("R3 smb base moved", d, 32'h0000_3491);
        probe(16'h3495);
        check("R9 pm wins", {30'd0, pm_hit, smb_hit}, 32'h2);
        check("R9 pm off", {25'd0, pm_off}, 32'h15);
        cfg_write(6'h10, 4'b0010, 32'h0000_0000);
        probe(16'h3495);
        check("R9 smb alone", {30'd0, pm_hit, smb_hit}, 32'h1);
        check("R8 smb off", {28'd0, smb_off}, 32'h5);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 6'h24; cfg_be = 4'hF; cfg_wdata = 32'h0000_7777;
        #1 check("R10 old value", cfg_rdata, 32'h0000_3491);
        @(posedge clk);
        #1 cfg_wr = 1'b0; cfg_be = '0;
        check("R10 new value", cfg_rdata, 32'h0000_7771);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        cfg_write(6'h20, 4'hF, 32'hFFFF_FFFF);
        cfg_read(6'h20, d); check("R11 unmapped reads zero", d, 32'h0);
        cfg_read(6'h12, d); check("R11 pm base kept", d, 32'h0000_3481);
        cfg_read(6'h24, d); check("R11 smb base kept", d, 32'h0000_7771);
        probe(16'h7775);
        check("R11 smb still on", {30'd0, pm_hit, smb_hit}, 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pm_base();
        t_smb_base();
        t_partial();
        t_pm_enable();
        t_smb_enable();
        t_priority();
        t_same_cycle();
        t_unmapped();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule